// File: doc/BRIEF.md
# Restartable Three-Pulse Timer

This block is a small Moore state machine that measures a short fixed interval once a restart request is let go. While nothing is requested it rests in an idle state that shows a count of 3 with the beeper silent. Raising the restart input parks the machine in a hold state that shows a count of 0. The hold state lasts for as long as the request stays high. Dropping the request starts a four-step count: the count shows 0, 1, 2 and then 3, one clock period each. The beeper sounds only on the last step, and then the machine goes back to idle.

A restart request seen on any clock edge during the count cancels the count and returns the machine to hold. The count then runs again from its first step once the request is released. The outputs are decoded from the state register alone, so a change on the restart input between clock edges never reaches them. The restart input is assumed to be already synchronous to the clock.

The design splits into two parts under a thin top. A control part holds the 3-bit state register and the next-state logic. An output part turns a small bundle of state strobes into the count and the beeper.

Top module: `restart_timer`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle: on the cycle after a clock edge with `rst`=1, `countAb`=2'b11 and `beep`=0.
- R2: In idle, each clock edge that samples `restartReq`=0 keeps the machine in idle (`countAb`=2'b11, `beep`=0).
- R3: In idle, a clock edge that samples `restartReq`=1 moves the machine to hold, where `countAb`=2'b00 and `beep`=0.
- R4: In hold, each clock edge that samples `restartReq`=1 keeps the machine in hold, for any number of cycles.
- R5: In hold, a clock edge that samples `restartReq`=0 starts the count. With `restartReq` kept at 0, the outputs {`countAb`,`beep`} are 3'b000, 3'b010, 3'b100 and 3'b111 for exactly one clock each. The next edge then returns the machine to idle. The first step is a state of its own, separate from hold.
- R6: A clock edge that samples `restartReq`=1 during any of the four count steps moves the machine to hold. A later release runs the count again from its first step.
- R7: `beep` is 1 only during the last count step, and only while `countAb`=2'b11.
- R8: The outputs depend only on the state register. A change of `restartReq` between clock edges leaves `countAb` and `beep` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| restartReq | input | 1 | Restart request, sampled on each rising edge |
| countAb | output | 2 | Count value shown by the current state |
| beep | output | 1 | Beeper, high only on the last count step |

## Verification
Random restart requests with run lengths between one and many cycles are checked every cycle against a state model kept in the bench. One-cycle pulses show whether hold lasts only as long as the request, and long runs show that hold stays put. Directed restarts at each of the four count steps tell a correct return to hold apart from a count that carries on or resumes mid-way. Long idle stretches confirm that the machine stays in idle. Toggling the request between edges, with the outputs checked before the next edge, separates a Moore decode from one that looks at the input directly.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int STATE_W = 3;
  localparam int CNT_W   = 2;
  localparam logic [CNT_W-1:0] LAST_STEP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] IDLE_SHOW = {CNT_W{1'b1}};

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'b000,
    ST_HOLD  = 3'b001,
    ST_STEP0 = 3'b100,
    ST_STEP1 = 3'b101,
    ST_STEP2 = 3'b110,
    ST_STEP3 = 3'b111
  } timer_state_t;

  typedef struct packed {
    logic             holdOn;
    logic             stepOn;
    logic [CNT_W-1:0] stepIdx;
  } ctrl_strb_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restartReq,
  output ctrl_strb_t strb
);
  timer_state_t stateQ, stateD;

  always_comb begin
    case (stateQ)
      ST_IDLE:  stateD = restartReq ? ST_HOLD : ST_IDLE;
      ST_HOLD:  stateD = restartReq ? ST_HOLD : ST_STEP0;
      ST_STEP0: stateD = restartReq ? ST_HOLD : ST_STEP1;
      ST_STEP1: stateD = restartReq ? ST_HOLD : ST_STEP2;
      ST_STEP2: stateD = restartReq ? ST_HOLD : ST_STEP3;
      ST_STEP3: stateD = restartReq ? ST_HOLD : ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign strb.holdOn  = (stateQ == ST_HOLD);
  assign strb.stepOn  = stateQ[STATE_W-1];
  assign strb.stepIdx = stateQ[CNT_W-1:0];

  // R3: idle plus request goes to hold
  a_r3_idle_to_hold: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && restartReq) |=> (stateQ == ST_HOLD));
  // R4: hold persists while requested
  a_r4_hold_stays: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD && restartReq) |=> (stateQ == ST_HOLD));
  // R5: release from hold always enters the first step
  a_r5_release_step0: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD && !restartReq) |=> (stateQ == ST_STEP0));
  // R5: last step without request returns to idle
  a_r5_last_to_idle: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_STEP3 && !restartReq) |=> (stateQ == ST_IDLE));
  // R6: request during any step returns to hold
  a_r6_step_restart: assert property (@(posedge clk) disable iff (rst)
    (stateQ[STATE_W-1] && restartReq) |=> (stateQ == ST_HOLD));
endmodule

// File: rtl/timer_outdec.sv
module timer_outdec
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strb_t       strb,
  output logic [CNT_W-1:0] countAb,
  output logic             beep
);
  always_comb begin
    if (strb.stepOn)      countAb = strb.stepIdx;
    else if (strb.holdOn) countAb = '0;
    else                  countAb = IDLE_SHOW;
  end

  assign beep = strb.stepOn && (strb.stepIdx == LAST_STEP);

  // R7: beeper only together with the full count
  a_r7_beep_last: assert property (@(posedge clk) disable iff (rst)
    beep |-> (countAb == LAST_STEP));
  // R1: reset lands in idle outputs
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (countAb == IDLE_SHOW && !beep));
endmodule

// File: rtl/restart_timer.sv
module restart_timer
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restartReq,
  output logic [1:0] countAb,
  output logic       beep
);
  ctrl_strb_t strb;

  timer_ctrl ctrl_i (
    .clk(clk), .rst(rst), .restartReq(restartReq), .strb(strb)
  );

  timer_outdec outdec_i (
    .clk(clk), .rst(rst), .strb(strb), .countAb(countAb), .beep(beep)
  );
endmodule

// File: tb/restart_timer_tb_top.sv
module restart_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restartReq = 1'b0;
  logic [1:0] countAb;
  logic beep;

  int total = 0;
  int bad = 0;
  int mState = 0; // 0 idle, 1 hold, 2..5 count steps 0..3

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_timer dut_i (
    .clk(clk), .rst(rst), .restartReq(restartReq),
    .countAb(countAb), .beep(beep)
  );

  function automatic logic [1:0] expAb(int s);
    if (s == 0) return 2'b11;
    if (s == 1) return 2'b00;
    return 2'(s - 2);
  endfunction

  function automatic logic expBeep(int s);
    return (s == 5);
  endfunction

  function automatic int nextState(int s, logic r, logic rs);
    if (rs) return 0;
    if (r) return 1;
    if (s == 0) return 0;
    if (s == 5) return 0;
    return s + 1;
  endfunction

  function automatic string tagFor(int s, logic r, logic rs);
    if (rs) return "R1";
    if (s == 0) return r ? "R3" : "R2";
    if (s == 1) return r ? "R4" : "R5";
    return r ? "R6" : ((s == 5) ? "R7" : "R5");
  endfunction

  task automatic checkOut(string tag);
    total++;
    if (countAb !== expAb(mState) || beep !== expBeep(mState)) begin
      bad++;
      $display("FAIL %s: got ab=%b c=%b expected ab=%b c=%b (model state %0d)",
               tag, countAb, beep, expAb(mState), expBeep(mState), mState);
    end
  endtask

  // one clock: drive at negedge, check the R8 rule mid-cycle, model the edge, check after it
  task automatic step(logic r, logic rs = 1'b0, logic wiggle = 1'b0);
    string tag;
    restartReq = r;
    rst = rs;
    if (wiggle) begin
      #1 restartReq = ~r;
      #1 checkOut("R8");
      restartReq = r;
    end
    tag = tagFor(mState, r, rs);
    @(posedge clk);
    mState = nextState(mState, r, rs);
    @(negedge clk);
    checkOut(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);            // R1 reset state
    // R2 long idle
    for (int i = 0; i < 40; i++) step(1'b0);
    // R3 one-cycle pulse, then full count R5/R7
    step(1'b1);
    for (int i = 0; i < 6; i++) step(1'b0);
    // R4 long hold
    for (int i = 0; i < 25; i++) step(1'b1);
    for (int i = 0; i < 6; i++) step(1'b0);
    // R6 restart at each count step k, then rerun whole count
    for (int k = 0; k < 4; k++) begin
      step(1'b1);
      step(1'b0);
      for (int j = 0; j < k; j++) step(1'b0);
      step(1'b1);
      for (int j = 0; j < 6; j++) step(1'b0);
    end
    // R1 reset mid-count
    step(1'b1); step(1'b0); step(1'b0);
    step(1'b0, 1'b1);
    step(1'b0);
    // R8 wiggles in every state
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1);
    // random runs of varying length
    for (int n = 0; n < 300; n++) begin
      int len = int'($urandom_range(1, 9));
      logic r = 1'($urandom_range(0, 1));
      for (int j = 0; j < len; j++) step(r, 1'b0, 1'($urandom_range(0, 3) == 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule